// File: doc/BRIEF.md
# Audio Oversampling Clock Generator

This block produces the three clocks of a stereo serial audio port: a master clock for the codec, a bit clock and a left/right frame clock. It runs on a core clock at twice the reference rate. The reference is either 512 or 384 times the sample rate (fs). The master clock divides the reference by a power of two. The bit clock runs at 32fs or 48fs on either base. A phase accumulator spreads the bit-clock edges, so the combination of a 512fs base with a 48fs bit clock still yields whole frames.

A configuration write carries the base-rate select, the MCLK divide code and the bit-clock width select. A write is accepted only while the port is idle and only when the code is legal for the chosen base. Run, gate, soft reset and slave select are level inputs. In slave mode the bit and frame clocks are taken from a neighbouring port, while MCLK is still made locally. Each output clock comes with a one-cycle pulse that marks its rising edge. Logic that works on the core clock uses this pulse as its enable.

Top module: `aclk_gen`

## Requirements
- R1: After reset, every clock output, every rising-edge pulse, busy_o and cfg_err_o are 0. The configuration is base 512fs, code 0 and a 32fs bit clock.
- R2: While running, mclk_o has a period of 2^(code+1) core cycles. The core clock is twice the reference, so MCLK = reference / 2^code.
- R3: A configuration write made while idle is rejected if the code is above 4 with the 512fs base (cfg_base_lo_i=0) or above 3 with the 384fs base (cfg_base_lo_i=1). A rejection sets cfg_err_o and keeps the previous configuration. A legal idle write loads the configuration and clears cfg_err_o.
- R4: The lrclk_o period is 1024 core cycles with the 512fs base and 768 with the 384fs base. Each period contains 32 bclk_o rising edges when cfg_wide_i=0 and 48 when cfg_wide_i=1.
- R5: lrclk_o changes on bit-clock falling edges. Each half frame holds 16 (narrow) or 24 (wide) bit-clock periods, so its high phase lasts exactly half the frame.
- R6: busy_o rises one cycle after run_i is seen while idle. After run_i is cleared, the block stops only at the next frame-clock falling edge. The last high phase of lrclk_o has full length, and all clocks are 0 from the cycle busy_o falls.
- R7: While gate_i is 1 (and srst_i is 0), all clock outputs and busy_o hold their values and the rising-edge pulses are 0.
- R8: With slave_i=1 and running, bclk_o and lrclk_o copy ext_bclk_i and ext_lrclk_i one cycle later, and mclk_o is still generated locally.
- R9: srst_i forces all clock outputs and busy_o to 0 on the next cycle and clears every divider. After it is released with run_i high, the frame timing starts again from zero.
- R10: A configuration write while busy_o is 1 is ignored. Neither the active configuration nor cfg_err_o changes.
- R11: mclk_rise_o, bclk_rise_o and lrclk_rise_o are 1 exactly in the cycles where the matching clock output has just gone from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_base_lo_i | input | 1 | 0: 512fs base, 1: 384fs base |
| cfg_code_i | input | 3 | MCLK divide code (divide by 2^code) |
| cfg_wide_i | input | 1 | 0: 32fs bit clock, 1: 48fs bit clock |
| run_i | input | 1 | Run enable |
| gate_i | input | 1 | Freeze all clocks |
| srst_i | input | 1 | Soft reset of dividers and outputs |
| slave_i | input | 1 | Take bit and frame clocks from ext inputs |
| ext_bclk_i | input | 1 | Bit clock from the neighbouring port |
| ext_lrclk_i | input | 1 | Frame clock from the neighbouring port |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame (left/right) clock |
| mclk_rise_o | output | 1 | Rising-edge pulse of mclk_o |
| bclk_rise_o | output | 1 | Rising-edge pulse of bclk_o |
| lrclk_rise_o | output | 1 | Rising-edge pulse of lrclk_o |
| busy_o | output | 1 | Port running |
| cfg_err_o | output | 1 | Last idle configuration write was illegal |

## Verification
The hardest state to reach is the stop at a frame boundary. The clear of run_i can fall in either half of the frame, and the block must still finish a whole high phase of lrclk_o before going idle. The stimulus clears run_i in the middle of a running frame. A monitor records the length of every lrclk_o high phase, so the last high phase before busy_o falls can be compared with half a frame. The fractional case (512fs base with a 48fs bit clock) is driven deliberately, so that the uneven spacing of the bit-clock edges is checked against the frame length.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    // Positions of the three clocks inside the level and pulse vectors
    localparam int LVL_M  = 0;
    localparam int LVL_B  = 1;
    localparam int LVL_LR = 2;
    localparam int LVL_N  = 3;

    typedef struct packed {
        logic             active;
        logic [LVL_N-1:0] lvl;
        logic [LVL_N-1:0] rise;
    } aclk_state_t;

endpackage

// File: rtl/aclk_cfg.sv
module aclk_cfg #(
    parameter int CODE_W      = 3,
    parameter int MAX_CODE_HI = 4,
    parameter int MAX_CODE_LO = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              busy_i,
    input  logic              base_lo_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              wide_i,
    output logic              base_lo_o,
    output logic [CODE_W-1:0] code_o,
    output logic              wide_o,
    output logic              err_o
);

    typedef struct packed {
        logic              base_lo;
        logic [CODE_W-1:0] code;
        logic              wide;
        logic              err;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic       legal_c;

    always_comb begin
        legal_c = base_lo_i ? (code_i <= CODE_W'(MAX_CODE_LO))
                            : (code_i <= CODE_W'(MAX_CODE_HI));
        s_d = s_q;
        if (wr_i && !busy_i) begin
            if (legal_c) begin
                s_d.base_lo = base_lo_i;
                s_d.code    = code_i;
                s_d.wide    = wide_i;
                s_d.err     = 1'b0;
            end else begin
                s_d.err     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign base_lo_o = s_q.base_lo;
    assign code_o    = s_q.code;
    assign wide_o    = s_q.wide;
    assign err_o     = s_q.err;

endmodule

// File: rtl/aclk_mclk_div.sv
module aclk_mclk_div #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              mclk_o
);

    localparam int CNT_W = 1 << CODE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mclk;
    } div_state_t;

    div_state_t       s_d, s_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        s_d    = s_q;
        cnt_nx = s_q.cnt + CNT_W'(1);
        if (clear_i) begin
            s_d = '0;
        end else if (en_i) begin
            s_d.cnt  = cnt_nx;
            s_d.mclk = cnt_nx[code_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mclk_o = s_q.mclk;

endmodule

// File: rtl/aclk_bclk_gen.sv
module aclk_bclk_gen #(
    parameter int BASE_HI     = 512,
    parameter int BASE_LO     = 384,
    parameter int BITS_NARROW = 32,
    parameter int BITS_WIDE   = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    input  logic base_lo_i,
    input  logic wide_i,
    output logic bclk_o,
    output logic lrclk_o
);

    // Core cycles per frame and bit-clock half periods per frame
    localparam int MOD_HI  = 2 * BASE_HI;
    localparam int MOD_LO  = 2 * BASE_LO;
    localparam int STEP_N  = 2 * BITS_NARROW;
    localparam int STEP_W  = 2 * BITS_WIDE;
    localparam int HALF_N  = BITS_NARROW / 2;
    localparam int HALF_W  = BITS_WIDE / 2;
    localparam int ACC_W   = $clog2(MOD_HI) + 2;
    localparam int BCNT_W  = $clog2(HALF_W) + 1;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [BCNT_W-1:0] bits;
        logic              bclk;
        logic              lrclk;
    } gen_state_t;

    gen_state_t        s_d, s_q;
    logic [ACC_W-1:0]  mod_c, step_c, sum_c;
    logic [BCNT_W-1:0] last_c;

    always_comb begin
        mod_c  = base_lo_i ? ACC_W'(MOD_LO) : ACC_W'(MOD_HI);
        step_c = wide_i    ? ACC_W'(STEP_W) : ACC_W'(STEP_N);
        last_c = wide_i    ? BCNT_W'(HALF_W - 1) : BCNT_W'(HALF_N - 1);
        sum_c  = s_q.acc + step_c;
        s_d    = s_q;
        if (clear_i) begin
            s_d = '0;
        end else if (en_i) begin
            if (sum_c >= mod_c) begin
                s_d.acc  = sum_c - mod_c;
                s_d.bclk = !s_q.bclk;
                if (s_q.bclk) begin
                    if (s_q.bits == last_c) begin
                        s_d.bits  = '0;
                        s_d.lrclk = !s_q.lrclk;
                    end else begin
                        s_d.bits  = s_q.bits + BCNT_W'(1);
                    end
                end
            end else begin
                s_d.acc = sum_c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bclk_o  = s_q.bclk;
    assign lrclk_o = s_q.lrclk;

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
    import aclk_pkg::*;
#(
    parameter int CODE_W      = 3,
    parameter int MAX_CODE_HI = 4,
    parameter int MAX_CODE_LO = 3,
    parameter int BASE_HI     = 512,
    parameter int BASE_LO     = 384,
    parameter int BITS_NARROW = 32,
    parameter int BITS_WIDE   = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic              cfg_base_lo_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    input  logic              cfg_wide_i,
    input  logic              run_i,
    input  logic              gate_i,
    input  logic              srst_i,
    input  logic              slave_i,
    input  logic              ext_bclk_i,
    input  logic              ext_lrclk_i,
    output logic              mclk_o,
    output logic              bclk_o,
    output logic              lrclk_o,
    output logic              mclk_rise_o,
    output logic              bclk_rise_o,
    output logic              lrclk_rise_o,
    output logic              busy_o,
    output logic              cfg_err_o
);

    aclk_state_t       s_d, s_q;
    logic              act_base_lo, act_wide;
    logic [CODE_W-1:0] act_code;
    logic              div_mclk, gen_bclk, gen_lrclk;
    logic              run_en, div_clear, gen_clear;
    logic              src_b, src_lr, stop_c;

    assign run_en    = s_q.active && !gate_i && !srst_i;
    assign div_clear = srst_i || !s_q.active;
    assign gen_clear = div_clear || slave_i;

    aclk_cfg #(
        .CODE_W      (CODE_W),
        .MAX_CODE_HI (MAX_CODE_HI),
        .MAX_CODE_LO (MAX_CODE_LO)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr_i),
        .busy_i    (s_q.active),
        .base_lo_i (cfg_base_lo_i),
        .code_i    (cfg_code_i),
        .wide_i    (cfg_wide_i),
        .base_lo_o (act_base_lo),
        .code_o    (act_code),
        .wide_o    (act_wide),
        .err_o     (cfg_err_o)
    );

    aclk_mclk_div #(
        .CODE_W (CODE_W)
    ) u_mdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (div_clear),
        .en_i    (run_en),
        .code_i  (act_code),
        .mclk_o  (div_mclk)
    );

    aclk_bclk_gen #(
        .BASE_HI     (BASE_HI),
        .BASE_LO     (BASE_LO),
        .BITS_NARROW (BITS_NARROW),
        .BITS_WIDE   (BITS_WIDE)
    ) u_bgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (gen_clear),
        .en_i      (run_en),
        .base_lo_i (act_base_lo),
        .wide_i    (act_wide),
        .bclk_o    (gen_bclk),
        .lrclk_o   (gen_lrclk)
    );

    always_comb begin
        src_b  = slave_i ? ext_bclk_i  : gen_bclk;
        src_lr = slave_i ? ext_lrclk_i : gen_lrclk;
        // A pending stop completes on the frame clock's falling edge
        stop_c = !run_i && s_q.lvl[LVL_LR] && !src_lr;
        s_d      = s_q;
        s_d.rise = '0;
        if (srst_i) begin
            s_d = '0;
        end else if (gate_i) begin
            s_d.rise = '0;
        end else if (!s_q.active) begin
            s_d.active = run_i;
            s_d.lvl    = '0;
        end else if (stop_c) begin
            s_d.active = 1'b0;
            s_d.lvl    = '0;
        end else begin
            s_d.lvl[LVL_M]  = div_mclk;
            s_d.lvl[LVL_B]  = src_b;
            s_d.lvl[LVL_LR] = src_lr;
            s_d.rise        = s_d.lvl & ~s_q.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o       = s_q.active;
    assign mclk_o       = s_q.lvl[LVL_M];
    assign bclk_o       = s_q.lvl[LVL_B];
    assign lrclk_o      = s_q.lvl[LVL_LR];
    assign mclk_rise_o  = s_q.rise[LVL_M];
    assign bclk_rise_o  = s_q.rise[LVL_B];
    assign lrclk_rise_o = s_q.rise[LVL_LR];

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk #(
    parameter int CODE_W      = 3,
    parameter int MAX_CODE_HI = 4,
    parameter int MAX_CODE_LO = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_i,
    input logic              cfg_base_lo_i,
    input logic [CODE_W-1:0] cfg_code_i,
    input logic              run_i,
    input logic              gate_i,
    input logic              srst_i,
    input logic              slave_i,
    input logic              ext_bclk_i,
    input logic              mclk_o,
    input logic              bclk_o,
    input logic              lrclk_o,
    input logic              mclk_rise_o,
    input logic              lrclk_rise_o,
    input logic              busy_o,
    input logic              cfg_err_o
);

    logic bad_code;
    assign bad_code = cfg_base_lo_i ? (cfg_code_i > CODE_W'(MAX_CODE_LO))
                                    : (cfg_code_i > CODE_W'(MAX_CODE_HI));

    // R9
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (!mclk_o && !bclk_o && !lrclk_o && !busy_o));

    // R7
    gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && !srst_i) |=> ($stable(mclk_o) && $stable(bclk_o)
                                 && $stable(lrclk_o) && $stable(busy_o)));

    // R6
    frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(srst_i)) |-> $past(lrclk_o));

    // R8
    slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && slave_i && run_i && !gate_i && !srst_i)
            |=> (bclk_o == $past(ext_bclk_i)));

    // R3
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !busy_o && bad_code) |=> cfg_err_o);

    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && busy_o) |=> $stable(cfg_err_o));

    // R11
    mclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_rise_o == (mclk_o && !$past(mclk_o)));

    // R11
    lrclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lrclk_rise_o == (lrclk_o && !$past(lrclk_o)));

endmodule

bind aclk_gen aclk_gen_chk #(
    .CODE_W      (CODE_W),
    .MAX_CODE_HI (MAX_CODE_HI),
    .MAX_CODE_LO (MAX_CODE_LO)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_base_lo_i (cfg_base_lo_i),
    .cfg_code_i    (cfg_code_i),
    .run_i         (run_i),
    .gate_i        (gate_i),
    .srst_i        (srst_i),
    .slave_i       (slave_i),
    .ext_bclk_i    (ext_bclk_i),
    .mclk_o        (mclk_o),
    .bclk_o        (bclk_o),
    .lrclk_o       (lrclk_o),
    .mclk_rise_o   (mclk_rise_o),
    .lrclk_rise_o  (lrclk_rise_o),
    .busy_o        (busy_o),
    .cfg_err_o     (cfg_err_o)
);

// File: tb/aclk_gen_tb.sv
`timescale 1ns/1ps
module aclk_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_i = 1'b0, cfg_base_lo_i = 1'b0, cfg_wide_i = 1'b0;
    logic [2:0] cfg_code_i = 3'd0;
    logic       run_i = 1'b0, gate_i = 1'b0, srst_i = 1'b0, slave_i = 1'b0;
    logic       ext_bclk_i = 1'b0, ext_lrclk_i = 1'b0;
    logic       mclk_o, bclk_o, lrclk_o;
    logic       mclk_rise_o, bclk_rise_o, lrclk_rise_o, busy_o, cfg_err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = !clk;

    aclk_gen u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr_i (cfg_wr_i), .cfg_base_lo_i (cfg_base_lo_i),
        .cfg_code_i (cfg_code_i), .cfg_wide_i (cfg_wide_i),
        .run_i (run_i), .gate_i (gate_i), .srst_i (srst_i), .slave_i (slave_i),
        .ext_bclk_i (ext_bclk_i), .ext_lrclk_i (ext_lrclk_i),
        .mclk_o (mclk_o), .bclk_o (bclk_o), .lrclk_o (lrclk_o),
        .mclk_rise_o (mclk_rise_o), .bclk_rise_o (bclk_rise_o),
        .lrclk_rise_o (lrclk_rise_o), .busy_o (busy_o), .cfg_err_o (cfg_err_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitors: lrclk high-phase length and rising-edge pulse agreement
    int  hi_cnt = 0, last_hi = 0, pulse_err = 0;
    logic pm = 1'b0, pb = 1'b0, pl = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mclk_rise_o != (mclk_o && !pm)) pulse_err++;
            if (bclk_rise_o != (bclk_o && !pb)) pulse_err++;
            if (lrclk_rise_o != (lrclk_o && !pl)) pulse_err++;
            if (lrclk_o) hi_cnt++;
            else if (pl) begin last_hi = hi_cnt; hi_cnt = 0; end
        end
        pm = mclk_o; pb = bclk_o; pl = lrclk_o;
    end

    task automatic write_cfg(input bit base_lo, input int code, input bit wide);
        @(negedge clk);
        cfg_base_lo_i = base_lo; cfg_code_i = 3'(code); cfg_wide_i = wide;
        cfg_wr_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic start_run();
        @(negedge clk);
        run_i = 1'b1;
        @(negedge clk);
        chk("R6", "busy one cycle after run", int'(busy_o), 1);
    endtask

    task automatic mclk_period(output int cyc);
        cyc = 0;
        do @(negedge clk); while (!mclk_rise_o);
        do begin @(negedge clk); cyc++; end while (!mclk_rise_o);
    endtask

    task automatic frame(output int cyc, output int nb, output int hb);
        cyc = 0; nb = 0; hb = 0;
        do @(negedge clk); while (!lrclk_rise_o);
        do begin
            @(negedge clk);
            cyc++;
            if (bclk_rise_o) begin nb++; if (lrclk_o) hb++; end
        end while (!lrclk_rise_o);
    endtask

    task automatic stop_run(input int half);
        int n = 0;
        repeat (100) @(negedge clk);
        run_i = 1'b0;
        do begin @(negedge clk); n++; end while (busy_o && n < 4000);
        #1;
        chk("R6", "busy falls within one frame", int'(n <= 2 * half + 4), 1);
        chk("R6", "last lrclk high phase length", last_hi, half);
        chk("R6", "clocks low after stop", int'({mclk_o, bclk_o, lrclk_o}), 0);
    endtask

    task automatic check_timing(input string tag, input int mper, input int base, input int bits);
        int c, nb, hb;
        mclk_period(c);
        chk("R2", {tag, " mclk period"}, c, mper);
        frame(c, nb, hb);
        chk("R4", {tag, " frame length"}, c, 2 * base);
        chk("R4", {tag, " bclk per frame"}, nb, bits);
        chk("R5", {tag, " bclk in high half"}, hb, bits / 2);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset",
            int'({mclk_o, bclk_o, lrclk_o, mclk_rise_o, bclk_rise_o, lrclk_rise_o}), 0);
        chk("R1", "busy after reset", int'(busy_o), 0);
        chk("R1", "err after reset", int'(cfg_err_o), 0);
    endtask

    task automatic t_default();
        start_run();
        check_timing("R1 default", 2, 512, 32);
        stop_run(512);
    endtask

    task automatic t_busy_write();
        int c;
        write_cfg(1'b0, 2, 1'b0);
        start_run();
        write_cfg(1'b1, 1, 1'b1);
        write_cfg(1'b0, 7, 1'b0);
        chk("R10", "err after writes while busy", int'(cfg_err_o), 0);
        stop_run(512);
        start_run();
        mclk_period(c);
        chk("R10", "mclk period keeps old code", c, 8);
        stop_run(512);
    endtask

    task automatic t_illegal();
        int c;
        write_cfg(1'b0, 5, 1'b0);
        chk("R3", "err on code 5 with 512 base", int'(cfg_err_o), 1);
        start_run();
        mclk_period(c);
        chk("R3", "config kept after rejection", c, 8);
        stop_run(512);
        write_cfg(1'b1, 4, 1'b0);
        chk("R3", "err on code 4 with 384 base", int'(cfg_err_o), 1);
        write_cfg(1'b1, 3, 1'b1);
        chk("R3", "err cleared by legal write", int'(cfg_err_o), 0);
    endtask

    task automatic t_lo_wide();
        start_run();
        check_timing("384 wide", 16, 384, 48);
        stop_run(384);
    endtask

    task automatic t_hi_wide_frac();
        write_cfg(1'b0, 4, 1'b1);
        start_run();
        check_timing("512 wide fractional", 32, 512, 48);
        stop_run(512);
    endtask

    task automatic t_gate();
        int c;
        logic [3:0] snap;
        int pulses = 0;
        start_run();
        repeat (57) @(negedge clk);
        gate_i = 1'b1;
        @(negedge clk);
        snap = {busy_o, mclk_o, bclk_o, lrclk_o};
        repeat (40) begin
            @(negedge clk);
            if (mclk_rise_o || bclk_rise_o || lrclk_rise_o) pulses++;
        end
        chk("R7", "outputs frozen under gate", int'({busy_o, mclk_o, bclk_o, lrclk_o}), int'(snap));
        chk("R7", "no pulses under gate", pulses, 0);
        gate_i = 1'b0;
        mclk_period(c);
        chk("R7", "mclk resumes after gate", c, 32);
        stop_run(512);
    endtask

    task automatic t_srst();
        int c, nb, hb;
        start_run();
        repeat (300) @(negedge clk);
        srst_i = 1'b1;
        @(negedge clk);
        chk("R9", "clocks low under soft reset", int'({mclk_o, bclk_o, lrclk_o}), 0);
        chk("R9", "busy low under soft reset", int'(busy_o), 0);
        repeat (2) @(negedge clk);
        srst_i = 1'b0;
        @(negedge clk);
        chk("R9", "busy back after release", int'(busy_o), 1);
        frame(c, nb, hb);
        chk("R9", "frame length after soft reset", c, 1024);
        chk("R9", "bclk per frame after soft reset", nb, 48);
        stop_run(512);
    endtask

    task automatic t_slave();
        int c, bad = 0;
        slave_i = 1'b1;
        start_run();
        for (int i = 0; i < 24; i++) begin
            ext_bclk_i = i[0] ^ i[2];
            ext_lrclk_i = 1'b0;
            @(negedge clk);
            if (bclk_o != ext_bclk_i) bad++;
        end
        chk("R8", "bclk follows ext one cycle later", bad, 0);
        ext_lrclk_i = 1'b1;
        @(negedge clk);
        chk("R8", "lrclk follows ext", int'(lrclk_o), 1);
        mclk_period(c);
        chk("R8", "mclk local in slave mode", c, 32);
        run_i = 1'b0;
        @(negedge clk);
        chk("R6", "slave busy held until lrclk falls", int'(busy_o), 1);
        ext_lrclk_i = 1'b0;
        @(negedge clk);
        chk("R6", "slave stop on ext lrclk fall", int'(busy_o), 0);
        slave_i = 1'b0;
        ext_bclk_i = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            finish_up();
        end
    end

    initial begin
        t_reset();
        t_default();
        t_busy_write();
        t_illegal();
        t_lo_wide();
        t_hi_wide_frac();
        t_gate();
        t_srst();
        t_slave();
        chk("R11", "rising-edge pulse mismatches", pulse_err, 0);
        if (!done) begin
            done = 1'b1;
            finish_up();
        end
    end

endmodule